// File: doc/BRIEF.md
# Six-Channel General-Purpose Timer

This peripheral holds six independent up-counting timers behind a small synchronous register bus. Each channel has a control word, a clock word, a count word and a compare word, and each counts on the ticks of one of two external tick sources. The fast source or the slow source is chosen per channel. The channel can count on every selected tick or on every second one. A channel runs in one of three operating modes. In one-shot mode it stops on a compare match. In repeat mode it restarts from zero on a match. In free-running mode it ignores the compare word and wraps around.

A compare match sets a pending flag for that channel. Two shared words sit in the global page at the bottom of the address space: an interrupt-enable mask, and a pending word that is cleared by writing ones to it. The single interrupt output is high when any pending flag is also enabled. Software normally disables a channel, programs its compare word, and then writes enable and counter-clear together so that the channel restarts from zero.

The bus has plain strobes, with no handshake. A write completes in the cycle in which `bus_wr` is high. Read data is registered and appears on `bus_rdata` on the clock edge that samples `bus_rd`. It then holds until the next read.

Top module: `gpt_multi_timer`

## Requirements
- R1: After reset every readable word returns 0, all channels are stopped, nothing is pending and `irq` is low.
- R2: Channel k (1..6) has its control word at byte address 0x10·k. Bit 0 is the run enable and bits 5:4 are the mode: 0 one-shot, 1 repeat, 2 or 3 free-running. Bit 1 always reads as 0, and clearing bit 0 leaves the mode field unchanged.
- R3: Writing 1 to control bit 1 sets the channel's count (0x10·k+8) to zero in that write's cycle, whatever the other bits hold.
- R4: While enabled, the count rises by one per qualifying tick. While disabled it holds its value.
- R5: Bit 4 of the clock word (0x10·k+4) selects the tick source: 0 selects `tick_fast` and 1 selects `tick_slow`. Ticks of the source that is not selected have no effect.
- R6: Bit 0 of the clock word set to 1 makes the channel count on every second tick of its source, starting from the second tick after a clear.
- R7: One-shot: a tick that finds the count equal to the compare word (0x10·k+0xC) sets the pending flag, clears the enable bit and leaves the count unchanged.
- R8: Repeat: the same matching tick sets the pending flag and reloads the count to 0, and the channel stays enabled. The period is compare+1 ticks.
- R9: In free-running mode (2 or 3) the count wraps from all ones to 0 and the channel never becomes pending.
- R10: The pending word is at 0x08, with channel k at bit k-1. Reading it returns the flags. Writing it clears each flag whose bit is 1, and bits written as 0 have no effect.
- R11: The interrupt-enable word is at 0x00, with channel k at bit k-1. `irq` is the OR over all channels of pending AND enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Byte address of the access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| tick_fast | input | 1 | Tick enable of the fast source |
| tick_slow | input | 1 | Tick enable of the slow source |
| irq | output | 1 | Combined interrupt request |

## Verification
The situation that is hardest to reach from the ports is the free-running wrap. The count cannot be written, so at 32 bits the wrap would need about four billion ticks. The bench therefore adds a second instance with an 8-bit counter and drives exactly 256 ticks through it, with the compare word left at 0. This shows both that the count wraps to zero and that a count equal to compare raises no flag. The bench reaches the one-shot stop and the repeat reload by counting ticks exactly up to the match. It reads the count just before the matching tick and again after it. During these steps the other channels share the fast source, so they show that one channel's match does not disturb its neighbours.

// File: rtl/gpt_pkg.sv
package gpt_pkg;

  typedef enum logic [1:0] {
    MODE_ONESHOT  = 2'd0,
    MODE_REPEAT   = 2'd1,
    MODE_FREE_ALT = 2'd2,
    MODE_FREE     = 2'd3
  } gpt_mode_e;

  // control word bit positions
  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_CLR_BIT  = 1;
  localparam int CTRL_MODE_LSB = 4;

  // clock word bit positions
  localparam int CLK_DIV_BIT = 0;
  localparam int CLK_SRC_BIT = 4;

  // word selectors inside a channel page (address bits 3:2)
  localparam logic [1:0] REG_CTRL = 2'd0;
  localparam logic [1:0] REG_CLK  = 2'd1;
  localparam logic [1:0] REG_CNT  = 2'd2;
  localparam logic [1:0] REG_CMP  = 2'd3;

  // word selectors inside the global page
  localparam logic [1:0] GLB_IEN = 2'd0;
  localparam logic [1:0] GLB_ACK = 2'd2;

endpackage

// File: rtl/gpt_tick_sel.sv
module gpt_tick_sel (
  input  logic clk,
  input  logic rst_n,
  input  logic src_sel,
  input  logic div2,
  input  logic run,
  input  logic phase_clr,
  input  logic tick_fast,
  input  logic tick_slow,
  output logic tick
);

  logic src_tick;
  logic phase_q;

  assign src_tick = src_sel ? tick_slow : tick_fast;

  // divide-by-2 phase: the second source tick after a clear qualifies
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
    end else if (phase_clr) begin
      phase_q <= 1'b0;
    end else if (run && src_tick && div2) begin
      phase_q <= ~phase_q;
    end
  end

  assign tick = run && src_tick && (!div2 || phase_q);

endmodule

// File: rtl/gpt_counter.sv
module gpt_counter
  import gpt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             ctrl_wr,
  input  logic             ctrl_en,
  input  logic             ctrl_clr,
  input  gpt_mode_e        ctrl_mode,
  input  logic [CNT_W-1:0] cmp_val,
  output logic             en_q,
  output gpt_mode_e        mode_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic             hit
);

  logic uses_cmp;

  // modes with bit 1 set are free-running and never compare
  assign uses_cmp = !mode_q[1];
  assign hit      = en_q && tick && !ctrl_wr && uses_cmp && (cnt_q == cmp_val);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      mode_q <= MODE_ONESHOT;
      cnt_q  <= '0;
    end else if (ctrl_wr) begin
      // a control write owns the cycle; the tick is dropped
      en_q   <= ctrl_en;
      mode_q <= ctrl_mode;
      if (ctrl_clr) cnt_q <= '0;
    end else if (en_q && tick) begin
      if (hit) begin
        if (mode_q == MODE_ONESHOT) en_q <= 1'b0;
        else                        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/gpt_channel.sv
module gpt_channel
  import gpt_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_fast,
  input  logic              tick_slow,
  input  logic              wr_ctrl,
  input  logic              wr_clk,
  input  logic              wr_cmp,
  input  logic [DATA_W-1:0] wdata,
  input  logic              ack_clr,
  output logic [DATA_W-1:0] rd_ctrl,
  output logic [DATA_W-1:0] rd_clk,
  output logic [DATA_W-1:0] rd_cnt,
  output logic [DATA_W-1:0] rd_cmp,
  output logic              en_q,
  output gpt_mode_e         mode_q,
  output logic [CNT_W-1:0]  cnt_q,
  output logic              pend_q
);

  logic             src_q;
  logic             div_q;
  logic [CNT_W-1:0] cmp_q;
  logic             tick;
  logic             hit;
  logic             clr_req;

  assign clr_req = wr_ctrl && wdata[CTRL_CLR_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q <= 1'b0;
      div_q <= 1'b0;
      cmp_q <= '0;
    end else begin
      if (wr_clk) begin
        src_q <= wdata[CLK_SRC_BIT];
        div_q <= wdata[CLK_DIV_BIT];
      end
      if (wr_cmp) cmp_q <= wdata[CNT_W-1:0];
    end
  end

  gpt_tick_sel u_tick (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_sel   (src_q),
    .div2      (div_q),
    .run       (en_q),
    .phase_clr (clr_req),
    .tick_fast (tick_fast),
    .tick_slow (tick_slow),
    .tick      (tick)
  );

  gpt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .ctrl_wr   (wr_ctrl),
    .ctrl_en   (wdata[CTRL_EN_BIT]),
    .ctrl_clr  (wdata[CTRL_CLR_BIT]),
    .ctrl_mode (gpt_mode_e'(wdata[CTRL_MODE_LSB +: 2])),
    .cmp_val   (cmp_q),
    .en_q      (en_q),
    .mode_q    (mode_q),
    .cnt_q     (cnt_q),
    .hit       (hit)
  );

  // a new match wins over a coincident acknowledge
  always_ff @(posedge clk) begin
    if (!rst_n)       pend_q <= 1'b0;
    else if (hit)     pend_q <= 1'b1;
    else if (ack_clr) pend_q <= 1'b0;
  end

  always_comb begin
    rd_ctrl = '0;
    rd_ctrl[CTRL_EN_BIT] = en_q;
    rd_ctrl[CTRL_MODE_LSB +: 2] = mode_q;
    rd_clk = '0;
    rd_clk[CLK_SRC_BIT] = src_q;
    rd_clk[CLK_DIV_BIT] = div_q;
    rd_cnt = '0;
    rd_cnt[CNT_W-1:0] = cnt_q;
    rd_cmp = '0;
    rd_cmp[CNT_W-1:0] = cmp_q;
  end

endmodule

// File: rtl/gpt_multi_timer.sv
module gpt_multi_timer
  import gpt_pkg::*;
#(
  parameter int NUM_TIMERS = 6,
  parameter int CNT_W      = 32,
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              tick_fast,
  input  logic              tick_slow,
  output logic              irq
);

  localparam int PAGE_W = ADDR_W - 4;

  logic [PAGE_W-1:0] page;
  logic [1:0]        wsel;
  logic              glb_hit;
  logic [NUM_TIMERS-1:0] chan_hit;
  logic [NUM_TIMERS-1:0] ien_q;
  logic [NUM_TIMERS-1:0] ack_bits;

  logic [NUM_TIMERS-1:0]            en_vec;
  logic [NUM_TIMERS-1:0]            pend_vec;
  logic [NUM_TIMERS-1:0][1:0]       mode_vec;
  logic [NUM_TIMERS-1:0][CNT_W-1:0] cnt_vec;

  logic [DATA_W-1:0] ch_ctrl [NUM_TIMERS];
  logic [DATA_W-1:0] ch_clk  [NUM_TIMERS];
  logic [DATA_W-1:0] ch_cnt  [NUM_TIMERS];
  logic [DATA_W-1:0] ch_cmp  [NUM_TIMERS];
  logic [DATA_W-1:0] rd_mux;

  assign page    = bus_addr[ADDR_W-1:4];
  assign wsel    = bus_addr[3:2];
  assign glb_hit = (page == '0);

  assign ack_bits = (bus_wr && glb_hit && wsel == GLB_ACK) ?
                    bus_wdata[NUM_TIMERS-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n)                                 ien_q <= '0;
    else if (bus_wr && glb_hit && wsel == GLB_IEN) ien_q <= bus_wdata[NUM_TIMERS-1:0];
  end

  for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_ch
    localparam logic [PAGE_W-1:0] PG = PAGE_W'(i + 1);
    gpt_mode_e mode_i;

    assign chan_hit[i] = (page == PG);

    gpt_channel #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_fast (tick_fast),
      .tick_slow (tick_slow),
      .wr_ctrl   (bus_wr && chan_hit[i] && wsel == REG_CTRL),
      .wr_clk    (bus_wr && chan_hit[i] && wsel == REG_CLK),
      .wr_cmp    (bus_wr && chan_hit[i] && wsel == REG_CMP),
      .wdata     (bus_wdata),
      .ack_clr   (ack_bits[i]),
      .rd_ctrl   (ch_ctrl[i]),
      .rd_clk    (ch_clk[i]),
      .rd_cnt    (ch_cnt[i]),
      .rd_cmp    (ch_cmp[i]),
      .en_q      (en_vec[i]),
      .mode_q    (mode_i),
      .cnt_q     (cnt_vec[i]),
      .pend_q    (pend_vec[i])
    );

    assign mode_vec[i] = mode_i;
  end

  always_comb begin
    rd_mux = '0;
    if (glb_hit) begin
      case (wsel)
        GLB_IEN: rd_mux[NUM_TIMERS-1:0] = ien_q;
        GLB_ACK: rd_mux[NUM_TIMERS-1:0] = pend_vec;
        default: rd_mux = '0;
      endcase
    end
    for (int i = 0; i < NUM_TIMERS; i++) begin
      if (chan_hit[i]) begin
        case (wsel)
          REG_CTRL: rd_mux = ch_ctrl[i];
          REG_CLK:  rd_mux = ch_clk[i];
          REG_CNT:  rd_mux = ch_cnt[i];
          default:  rd_mux = ch_cmp[i];
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  assign irq = |(pend_vec & ien_q);

endmodule

// File: rtl/gpt_checker.sv
module gpt_checker #(
  parameter int NUM_TIMERS = 6,
  parameter int CNT_W      = 32,
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            bus_wr,
  input logic [ADDR_W-1:0]               bus_addr,
  input logic [DATA_W-1:0]               bus_wdata,
  input logic                            irq,
  input logic [NUM_TIMERS-1:0]           ien_q,
  input logic [NUM_TIMERS-1:0]           en_vec,
  input logic [NUM_TIMERS-1:0]           pend_vec,
  input logic [NUM_TIMERS-1:0][1:0]      mode_vec,
  input logic [NUM_TIMERS-1:0][CNT_W-1:0] cnt_vec
);

  // R11
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_q == '0) |-> !irq);

  for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_chk
    logic ctrl_sel;
    assign ctrl_sel = (bus_addr[ADDR_W-1:4] == (ADDR_W-4)'(i + 1)) && (bus_addr[3:2] == 2'd0);

    // R3
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && ctrl_sel && bus_wdata[1]) |=> (cnt_vec[i] == '0));

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_vec[i] && !bus_wr) |=> $stable(cnt_vec[i]));

    // R7
    oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(pend_vec[i]) && mode_vec[i] == 2'd0) |-> !en_vec[i]);

    // R8
    repeat_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(pend_vec[i]) && mode_vec[i] == 2'd1) |-> (en_vec[i] && cnt_vec[i] == '0));

    // R9
    freerun_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend_vec[i]) |-> !mode_vec[i][1]);
  end

endmodule

bind gpt_multi_timer gpt_checker #(
  .NUM_TIMERS(NUM_TIMERS),
  .CNT_W     (CNT_W),
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .irq       (irq),
  .ien_q     (ien_q),
  .en_vec    (en_vec),
  .pend_vec  (pend_vec),
  .mode_vec  (mode_vec),
  .cnt_vec   (cnt_vec)
);

// File: tb/gpt_multi_timer_bench.sv
`timescale 1ns/1ps
module gpt_multi_timer_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        wr_m = 1'b0, rd_m = 1'b0, wr_n = 1'b0, rd_n = 1'b0;
  logic        tick_fast = 1'b0, tick_slow = 1'b0;
  logic [31:0] rdata_m, rdata_n;
  logic        irq_m, irq_n;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  gpt_multi_timer u_gpt_multi_timer (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(wr_m), .bus_rd(rd_m),
    .bus_wdata(bus_wdata), .bus_rdata(rdata_m), .tick_fast(tick_fast),
    .tick_slow(tick_slow), .irq(irq_m)
  );

  // narrow counter so that a free-running wrap is reachable
  gpt_multi_timer #(.CNT_W(8)) u_narrow (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(wr_n), .bus_rd(rd_n),
    .bus_wdata(bus_wdata), .bus_rdata(rdata_n), .tick_fast(tick_fast),
    .tick_slow(tick_slow), .irq(irq_n)
  );

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000 && !done) begin
      done = 1'b1;
      fails++;
      checks++;
      $display("FAIL watchdog: actual cycles %0d expected completion", cyc);
      summary();
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input bit nar, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d;
    if (nar) wr_n = 1'b1; else wr_m = 1'b1;
    @(negedge clk);
    wr_m = 1'b0; wr_n = 1'b0;
  endtask

  task automatic rd(input bit nar, input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    if (nar) rd_n = 1'b1; else rd_m = 1'b1;
    @(negedge clk);
    rd_m = 1'b0; rd_n = 1'b0;
    d = nar ? rdata_n : rdata_m;
  endtask

  task automatic ticks(input bit slow, input int n);
    @(negedge clk);
    if (slow) tick_slow = 1'b1; else tick_fast = 1'b1;
    repeat (n) @(negedge clk);
    tick_slow = 1'b0; tick_fast = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(0, 8'h00, d); chk("R1 ien", d, 32'h0);
    rd(0, 8'h08, d); chk("R1 pending", d, 32'h0);
    rd(0, 8'h10, d); chk("R1 ctrl1", d, 32'h0);
    rd(0, 8'h18, d); chk("R1 cnt1", d, 32'h0);
    rd(0, 8'h6C, d); chk("R1 cmp6", d, 32'h0);
    chk("R1 irq", {31'h0, irq_m}, 32'h0);
  endtask

  task automatic t_ctrl_fields();
    logic [31:0] d;
    wr(0, 8'h10, 32'h33);
    rd(0, 8'h10, d); chk("R2 ctrl readback, clear bit 0", d, 32'h31);
    wr(0, 8'h10, 32'h30);
    rd(0, 8'h10, d); chk("R2 disable keeps mode", d, 32'h30);
  endtask

  task automatic t_count();
    logic [31:0] d;
    wr(0, 8'h10, 32'h33);
    ticks(0, 10);
    rd(0, 8'h18, d); chk("R4 count 10 ticks", d, 32'd10);
    wr(0, 8'h10, 32'h30);
    ticks(0, 5);
    rd(0, 8'h18, d); chk("R4 hold when disabled", d, 32'd10);
    wr(0, 8'h10, 32'h33);
    rd(0, 8'h18, d); chk("R3 clear zeroes count", d, 32'd0);
  endtask

  task automatic t_source();
    logic [31:0] d;
    wr(0, 8'h24, 32'h10);
    wr(0, 8'h20, 32'h33);
    ticks(0, 7);
    rd(0, 8'h28, d); chk("R5 fast ignored on slow source", d, 32'd0);
    ticks(1, 4);
    rd(0, 8'h28, d); chk("R5 slow ticks counted", d, 32'd4);
  endtask

  task automatic t_divide();
    logic [31:0] d;
    wr(0, 8'h34, 32'h01);
    wr(0, 8'h30, 32'h33);
    ticks(0, 1);
    rd(0, 8'h38, d); chk("R6 first tick skipped", d, 32'd0);
    ticks(0, 9);
    rd(0, 8'h38, d); chk("R6 half rate", d, 32'd5);
  endtask

  task automatic t_oneshot();
    logic [31:0] d;
    wr(0, 8'h4C, 32'd5);
    wr(0, 8'h00, 32'h08);
    wr(0, 8'h40, 32'h03);
    ticks(0, 5);
    rd(0, 8'h48, d); chk("R7 count before match", d, 32'd5);
    rd(0, 8'h08, d); chk("R7 not pending yet", d, 32'h0);
    ticks(0, 1);
    rd(0, 8'h08, d); chk("R7 pending on match", d, 32'h08);
    rd(0, 8'h40, d); chk("R7 enable cleared", d, 32'h00);
    ticks(0, 3);
    rd(0, 8'h48, d); chk("R7 count held", d, 32'd5);
    chk("R11 irq on enabled pending", {31'h0, irq_m}, 32'h1);
  endtask

  task automatic t_ack();
    logic [31:0] d;
    wr(0, 8'h08, 32'h37);
    rd(0, 8'h08, d); chk("R10 zero bit no effect", d, 32'h08);
    chk("R10 irq still high", {31'h0, irq_m}, 32'h1);
    wr(0, 8'h08, 32'h08);
    rd(0, 8'h08, d); chk("R10 one bit clears", d, 32'h0);
    chk("R11 irq low after ack", {31'h0, irq_m}, 32'h0);
  endtask

  task automatic t_repeat();
    logic [31:0] d;
    wr(0, 8'h5C, 32'd3);
    wr(0, 8'h50, 32'h13);
    ticks(0, 4);
    rd(0, 8'h08, d); chk("R8 pending after period", d, 32'h10);
    rd(0, 8'h58, d); chk("R8 reload to zero", d, 32'd0);
    chk("R11 masked pending no irq", {31'h0, irq_m}, 32'h0);
    ticks(0, 2);
    rd(0, 8'h58, d); chk("R8 keeps counting", d, 32'd2);
    rd(0, 8'h50, d); chk("R8 stays enabled", d, 32'h11);
    wr(0, 8'h00, 32'h18);
    rd(0, 8'h00, d); chk("R11 ien readback", d, 32'h18);
    chk("R11 irq after enable", {31'h0, irq_m}, 32'h1);
    wr(0, 8'h50, 32'h10);
    wr(0, 8'h08, 32'h10);
    chk("R11 irq cleared", {31'h0, irq_m}, 32'h0);
  endtask

  task automatic t_freerun();
    logic [31:0] d;
    wr(0, 8'h60, 32'h23);
    ticks(0, 6);
    rd(0, 8'h68, d); chk("R9 mode 2 counts", d, 32'd6);
    rd(0, 8'h08, d); chk("R9 mode 2 never pending", d, 32'h0);
    wr(1, 8'h10, 32'h33);
    ticks(0, 256);
    rd(1, 8'h18, d); chk("R9 wrap to zero", d, 32'd0);
    ticks(0, 3);
    rd(1, 8'h18, d); chk("R9 counts after wrap", d, 32'd3);
    rd(1, 8'h08, d); chk("R9 no pending at compare", d, 32'h0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_ctrl_fields();
    t_count();
    t_source();
    t_divide();
    t_oneshot();
    t_ack();
    t_repeat();
    t_freerun();
    done = 1'b1;
    summary();
  end

endmodule